// File: doc/BRIEF.md
# Performance Counter Global Control Hub

This block sits above a set of performance counter groups and decides, for all of them at once, whether counting runs. Software reaches it through three 32-bit registers on a small synchronous bus: a control word, a sticky status word and a write-1-to-clear word. Each of four counter groups reports an overflow pulse and an interrupt-request pulse. The hub turns these into sticky status bits, raises a one-cycle interrupt on any chosen subset of eight cores, and, when armed, drops the global count enable by itself as soon as an interrupt arrives.

The global enable is held by a three-state run machine. `RUN_OFF` is the reset state. A control write with the enable bit set moves `RUN_OFF` or `RUN_FROZEN` to `RUN_ON`. A control write with the enable bit clear moves `RUN_ON` or `RUN_FROZEN` to `RUN_OFF`. An interrupt that arrives while freeze is armed sends whatever would have been `RUN_ON` to `RUN_FROZEN` instead, even when a write is asking for the enable in the same cycle. The enable output is high only in `RUN_ON`. `RUN_OFF` and `RUN_FROZEN` read the same from software. The difference is kept so that the transition table shows which of the two stopped the counting.

Register addresses: 0 is control, 1 is status, 2 is overflow clear, and 3 is unused.

Top module: `perf_mon_hub`

## Requirements
- R1: After reset, every register reads 0, and `cnt_enable`, `loc_enable`, `cnt_reset` and `core_irq` are all low.
- R2: Control reads back bit 31 as freeze-armed, bit 28 as the global enable, bits 8:1 as the core mask and bit 0 as the local enable. Bit 29 and every other bit read 0.
- R3: A control write with bit 29 set drives `cnt_reset` high for exactly the cycle that follows the write, and for no other cycle.
- R4: `cnt_enable` follows the last written bit 28, and `loc_enable` follows the last written bit 0, each from the cycle after the write.
- R5: When freeze is armed (control bit 31 = 1) and any `grp_irq` bit is high, `cnt_enable` is low from the next cycle on. This holds even if the same cycle carries a control write that sets bit 28.
- R6: Status bit i (i = 0..3) becomes 1 on the cycle after `grp_ovf[i]` is high, and stays 1 until it is cleared.
- R7: Status bit 30 becomes 1 on the cycle after any `grp_irq` bit is high, and stays 1 until it is cleared.
- R8: Status bit 31 becomes 1 whenever some overflow status bit goes from 0 to 1, and stays 1 until it is cleared.
- R9: Writing a 1 to bit 31, 30 or 3..0 of the clear register (address 2) clears only the matching status bit. A set event in the same cycle wins over the clear.
- R10: One cycle after any `grp_irq` bit is high, `core_irq` equals the core mask (bit k = core k). At all other times it is 0.
- R11: Read data for the address presented in cycle t appears in cycle t+1 and reflects the register values before that cycle's write. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| grp_ovf | input | 4 | Overflow pulse per counter group |
| grp_irq | input | 4 | Interrupt-request pulse per counter group |
| cnt_enable | output | 1 | Global count enable to all groups |
| cnt_reset | output | 1 | One-cycle reset to all counters |
| loc_enable | output | 1 | Enable for the hub's own local counters |
| core_irq | output | 8 | Interrupt pulse per core |

## Verification
If the run machine is in the wrong state, `cnt_enable` shows it on the very next cycle, and a control read shows it one cycle later. A lost or phantom status bit shows only on a status read, so the stimulus reads status often and between random clear writes. A wrong core mask or wrong pulse timing shows on `core_irq` in the cycle right after the interrupt. The directed cases cover the two same-cycle races: freeze against an enable write, and a set event against a clear write.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
    typedef enum logic [1:0] {
        RUN_OFF    = 2'd0,
        RUN_ON     = 2'd1,
        RUN_FROZEN = 2'd2
    } run_state_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;
    localparam int unsigned ADDR_CLR  = 2;

    localparam int unsigned BIT_ARM  = 31;
    localparam int unsigned BIT_CRST = 29;
    localparam int unsigned BIT_CEN  = 28;
    localparam int unsigned BIT_COND = 31;
    localparam int unsigned BIT_PMI  = 30;
endpackage

// File: rtl/pmh_ctrl.sv
module pmh_ctrl
    import pmh_pkg::*;
#(
    parameter int unsigned NUM_CORE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_arm,
    input  logic                wr_crst,
    input  logic                wr_cen,
    input  logic                wr_loc,
    input  logic [NUM_CORE-1:0] wr_mask,
    input  logic                irq_any,
    output logic                arm,
    output logic                cnt_enable,
    output logic                cnt_reset,
    output logic                loc_enable,
    output logic [NUM_CORE-1:0] core_mask
);
    run_state_t st, nxt;
    logic freeze_evt;

    assign freeze_evt = arm && irq_any;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RUN_OFF;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            RUN_OFF:    if (wr_ctrl && wr_cen) nxt = RUN_ON;
            RUN_ON:     if (wr_ctrl && !wr_cen) nxt = RUN_OFF;
            RUN_FROZEN: if (wr_ctrl) nxt = wr_cen ? RUN_ON : RUN_OFF;
            default:    nxt = RUN_OFF;
        endcase
        if (freeze_evt && nxt == RUN_ON) nxt = RUN_FROZEN;
    end

    // outputs
    always_comb cnt_enable = (st == RUN_ON);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm        <= 1'b0;
            loc_enable <= 1'b0;
            core_mask  <= '0;
            cnt_reset  <= 1'b0;
        end else begin
            cnt_reset <= wr_ctrl && wr_crst;
            if (wr_ctrl) begin
                arm        <= wr_arm;
                loc_enable <= wr_loc;
                core_mask  <= wr_mask;
            end
        end
    end

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_evt |=> !cnt_enable);
    assert_enable_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !freeze_evt) |=> (cnt_enable == $past(wr_cen)));
    assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_crst) |=> cnt_reset);
endmodule

// File: rtl/pmh_status.sv
module pmh_status #(
    parameter int unsigned NUM_GRP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_ovf,
    input  logic               irq_any,
    input  logic               clr_we,
    input  logic [NUM_GRP-1:0] clr_ov,
    input  logic               clr_pmi,
    input  logic               clr_cond,
    output logic [NUM_GRP-1:0] ov,
    output logic               pmi,
    output logic               cond
);
    logic [NUM_GRP-1:0] ov_clr;
    logic               rise_any;

    assign ov_clr   = clr_we ? clr_ov : '0;
    assign rise_any = |(grp_ovf & ~ov);

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_ov
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ov[g] <= 1'b0;
                else        ov[g] <= (ov[g] && !ov_clr[g]) || grp_ovf[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmi  <= 1'b0;
            cond <= 1'b0;
        end else begin
            pmi  <= (pmi && !(clr_we && clr_pmi)) || irq_any;
            cond <= (cond && !(clr_we && clr_cond)) || rise_any;
        end
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ov & $past(grp_ovf)) == '0));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ov) & ~$past(ov_clr) & ~ov) == '0));
    assert_pmi_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |=> pmi);
    assert_cond_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |=> cond);
endmodule

// File: rtl/pmh_irq_steer.sv
module pmh_irq_steer #(
    parameter int unsigned NUM_CORE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_any,
    input  logic [NUM_CORE-1:0] core_mask,
    output logic [NUM_CORE-1:0] core_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_irq <= '0;
        else        core_irq <= irq_any ? core_mask : '0;
    end

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(irq_any) |-> (core_irq == '0));
    assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |=> (core_irq == $past(core_mask)));
endmodule

// File: rtl/perf_mon_hub.sv
module perf_mon_hub
    import pmh_pkg::*;
#(
    parameter int unsigned NUM_GRP  = 4,
    parameter int unsigned NUM_CORE = 8,
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_GRP-1:0]  grp_ovf,
    input  logic [NUM_GRP-1:0]  grp_irq,
    output logic                cnt_enable,
    output logic                cnt_reset,
    output logic                loc_enable,
    output logic [NUM_CORE-1:0] core_irq
);
    localparam logic [DW-1:0] USED_MASK =
        (DW'(1) << BIT_ARM) | (DW'(1) << BIT_CRST) | (DW'(1) << BIT_CEN) |
        (DW'(1) << BIT_PMI) | ((DW'(1) << (NUM_CORE + 1)) - DW'(1)) |
        ((DW'(1) << NUM_GRP) - DW'(1));

    logic                irq_any, wr_ctrl, wr_clr, arm;
    logic [NUM_CORE-1:0] core_mask;
    logic [NUM_GRP-1:0]  ov;
    logic                pmi, cond;
    logic [DW-1:0]       ctrl_word, stat_word, rd_next;
    logic                unused_wbits;

    assign irq_any      = |grp_irq;
    assign wr_ctrl      = bus_we && (bus_addr == AW'(ADDR_CTRL));
    assign wr_clr       = bus_we && (bus_addr == AW'(ADDR_CLR));
    assign unused_wbits = ^(bus_wdata & ~USED_MASK);

    pmh_ctrl #(.NUM_CORE(NUM_CORE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
        .wr_arm(bus_wdata[BIT_ARM]), .wr_crst(bus_wdata[BIT_CRST]),
        .wr_cen(bus_wdata[BIT_CEN]), .wr_loc(bus_wdata[0]),
        .wr_mask(bus_wdata[NUM_CORE:1]), .irq_any(irq_any),
        .arm(arm), .cnt_enable(cnt_enable), .cnt_reset(cnt_reset),
        .loc_enable(loc_enable), .core_mask(core_mask)
    );

    pmh_status #(.NUM_GRP(NUM_GRP)) u_stat (
        .clk(clk), .rst_n(rst_n), .grp_ovf(grp_ovf), .irq_any(irq_any),
        .clr_we(wr_clr), .clr_ov(bus_wdata[NUM_GRP-1:0]),
        .clr_pmi(bus_wdata[BIT_PMI]), .clr_cond(bus_wdata[BIT_COND]),
        .ov(ov), .pmi(pmi), .cond(cond)
    );

    pmh_irq_steer #(.NUM_CORE(NUM_CORE)) u_steer (
        .clk(clk), .rst_n(rst_n), .irq_any(irq_any),
        .core_mask(core_mask), .core_irq(core_irq)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[BIT_ARM]      = arm;
        ctrl_word[BIT_CEN]      = cnt_enable;
        ctrl_word[NUM_CORE:1]   = core_mask;
        ctrl_word[0]            = loc_enable;
        stat_word = '0;
        stat_word[BIT_COND]     = cond;
        stat_word[BIT_PMI]      = pmi;
        stat_word[NUM_GRP-1:0]  = ov;
        if (bus_addr == AW'(ADDR_CTRL))      rd_next = ctrl_word;
        else if (bus_addr == AW'(ADDR_STAT)) rd_next = stat_word;
        else                                 rd_next = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    assert_rst_only_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reset |-> $past(bus_we && bus_addr == AW'(ADDR_CTRL) && bus_wdata[BIT_CRST]));
    assert_clr_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_addr >= AW'(ADDR_CLR)) |-> (bus_rdata == '0));
    assert_rst_bit_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[BIT_CRST]);
endmodule

// File: tb/sim_perf_mon_hub.sv
module sim_perf_mon_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  grp_ovf = '0;
    logic [3:0]  grp_irq = '0;
    logic        cnt_enable, cnt_reset, loc_enable;
    logic [7:0]  core_irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    bit       m_arm, m_en, m_loc, m_pmi, m_cond;
    bit [7:0] m_mask;
    bit [3:0] m_ov;
    bit [31:0] e_rd;
    bit        e_rst;
    bit [7:0]  e_irq;

    always #2 clk = ~clk;

    perf_mon_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_ovf(grp_ovf),
        .grp_irq(grp_irq), .cnt_enable(cnt_enable), .cnt_reset(cnt_reset),
        .loc_enable(loc_enable), .core_irq(core_irq)
    );

    function automatic bit [31:0] exp_read(input bit [1:0] a);
        if (a == 2'd0) return {m_arm, 2'b0, m_en, 19'b0, m_mask, m_loc};
        if (a == 2'd1) return {m_cond, m_pmi, 26'b0, m_ov};
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle: drive, clock, update model, compare
    task automatic cyc(input bit [1:0] a, input bit we, input bit [31:0] wd,
                       input bit [3:0] ovf, input bit [3:0] irq);
        bit [31:0] clr;
        bit        irq_any;
        bus_addr = a; bus_we = we; bus_wdata = wd; grp_ovf = ovf; grp_irq = irq;
        @(posedge clk); #1;
        irq_any = |irq;
        e_rd  = exp_read(a);
        e_irq = irq_any ? m_mask : 8'h0;
        e_rst = we && a == 2'd0 && wd[29];
        clr   = (we && a == 2'd2) ? wd : 32'h0;
        m_cond = (m_cond && !clr[31]) || |(ovf & ~m_ov);
        m_pmi  = (m_pmi && !clr[30]) || irq_any;
        m_ov   = (m_ov & ~clr[3:0]) | ovf;
        if (we && a == 2'd0) begin
            if (m_arm && irq_any) m_en = 1'b0; else m_en = wd[28];
            m_arm = wd[31]; m_loc = wd[0]; m_mask = wd[8:1];
        end else if (m_arm && irq_any) m_en = 1'b0;
        chk("R11 rdata", bus_rdata, e_rd);
        chk("R3 cnt_reset", {31'b0, cnt_reset}, {31'b0, e_rst});
        chk("R4 cnt_enable", {31'b0, cnt_enable}, {31'b0, m_en});
        chk("R4 loc_enable", {31'b0, loc_enable}, {31'b0, m_loc});
        chk("R10 core_irq", {24'b0, core_irq}, {24'b0, e_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 cnt_enable", {31'b0, cnt_enable}, 32'h0);
        chk("R1 core_irq", {24'b0, core_irq}, 32'h0);
        cyc(2'd0, 0, 0, 0, 0);
        chk("R1 ctrl read", bus_rdata, 32'h0);
        cyc(2'd1, 0, 0, 0, 0);
        chk("R1 status read", bus_rdata, 32'h0);

        // R2 readback, R3 pulse
        cyc(2'd0, 1, 32'hFFFF_FFFF, 0, 0);
        chk("R3 pulse high", {31'b0, cnt_reset}, 32'h1);
        cyc(2'd0, 0, 0, 0, 0);
        chk("R3 pulse one cycle", {31'b0, cnt_reset}, 32'h0);
        chk("R2 ctrl fields", bus_rdata, 32'h9000_01FF);

        // R10 steer to cores 2, 6, 7 without freeze
        cyc(2'd0, 1, (32'h1 << 28) | (32'hC4 << 1), 0, 0);
        cyc(2'd1, 0, 0, 0, 4'b0010);
        chk("R10 cores 2,6,7", {24'b0, core_irq}, 32'hC4);
        chk("R5 not armed keeps enable", {31'b0, cnt_enable}, 32'h1);
        cyc(2'd1, 0, 0, 0, 0);
        chk("R10 one cycle", {24'b0, core_irq}, 32'h0);
        chk("R7 pmi sticky", bus_rdata & 32'h4000_0000, 32'h4000_0000);

        // R5 freeze beats simultaneous enable write
        cyc(2'd0, 1, 32'h9000_0000, 0, 0);
        cyc(2'd0, 1, 32'h9000_0000, 0, 4'b1000);
        chk("R5 frozen", {31'b0, cnt_enable}, 32'h0);
        cyc(2'd0, 0, 0, 0, 0);
        chk("R5 enable reads 0", bus_rdata & 32'h1000_0000, 32'h0);

        // R6 R8 R9 set wins over clear
        cyc(2'd2, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(2'd2, 1, 32'h0000_000F, 4'b0101, 0);
        cyc(2'd1, 0, 0, 0, 0);
        chk("R9 set wins", bus_rdata & 32'hF, 32'h5);
        chk("R8 cond set", bus_rdata & 32'h8000_0000, 32'h8000_0000);
        cyc(2'd2, 1, 32'h0000_0001, 0, 0);
        cyc(2'd1, 0, 0, 0, 0);
        chk("R9 clear only bit 0", bus_rdata, 32'h8000_0004);
        cyc(2'd2, 0, 0, 0, 0);
        chk("R11 clear addr reads 0", bus_rdata, 32'h0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit [1:0]  a  = 2'($urandom % 4);
            bit        we = ($urandom % 3) == 0;
            bit [31:0] wd = $urandom;
            bit [3:0]  ov = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            bit [3:0]  iq = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            cyc(a, we, wd, ov, iq);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule